// File: doc/BRIEF.md
# Block Security Lookup Table Register Bank

This block is the software-facing side of a memory gate that splits a protected memory into equal blocks and marks each block as reserved for secure or for non-secure masters. It holds the per-block lookup table, 32 block bits per table word, and exports the whole table, the error-response choice and an interrupt line to a companion gate. When the gate turns a transfer away it presents two capture words to this block. The block keeps them, and raises its interrupt status, only if no earlier violation is still pending.

Software reaches the table through an index register and a single data window. The index can advance by itself after each full-word window access, wrapping at the last table word, so a loop of full-word accesses walks the table. A lockdown control bit freezes the control register, the table and the interrupt enable until reset. Non-secure masters see only the identification space. The register port is a request/ready port with a word address, byte strobes and a secure attribute. Each accepted request is answered with `req_ready` in the following cycle, and read data is valid in that same cycle.

Top module: `sec_lut_regbank`

## Requirements
- R1: After reset the register at byte offset 0x00 (control) reads 0x00000100, offset 0x18 (index) reads 0, offset 0x20 (status) reads 0, offset 0x28 (enable) reads 1, offsets 0x2C and 0x30 (capture words) read 0, every table bit on `lut_bits` is 0 and `irq` is 0.
- R2: Control keeps only bit 4 (error response, driven out on `gate_err_resp`), bit 8 (index auto-advance) and bit 31 (lockdown). All other control bits read 0 whatever is written.
- R3: A read or write at offset 0x1C with all four strobes set acts on the table word selected by the index. When control bit 8 is 1 the index then advances by one, and from the last word it wraps to 0. An access at 0x1C with any strobe clear never moves the index.
- R4: A write to offset 0x18 stores the written value modulo the number of table words. Offset 0x10 reads the number of table words minus one, and offset 0x14 reads log2(block bytes) minus 5.
- R5: An access with `req_secure` = 0 at any offset below 0xFD0 reads 0 and changes no state. It still gets `req_ready` in the next cycle.
- R6: While control bit 31 is 1, writes to offsets 0x00, 0x1C and 0x28 change nothing, including the index. The bit is cleared only by reset.
- R7: A write with some strobes clear merges the strobed bytes into the current value for offsets 0x00, 0x18 and 0x1C. For every other register the unstrobed bytes are taken as zero.
- R8: Writing a 1 in bit 0 of offset 0x24 clears the status and writing a 1 in bit 0 of offset 0x34 sets it. Offset 0x28 bit 0 is the enable, and `irq` equals status AND enable. Offsets 0x24 and 0x34 read 0.
- R9: The twelve words from 0xFD0 to 0xFFC read, in address order, the bytes 04, 00, 00, 00, 60, B8, 1B, 00, 0D, F0, 05, B1 in bits 7:0, with zero above. They read the same for secure and non-secure masters, and writes to them change nothing.
- R10: A `cap_valid` pulse while the status is 0 loads `cap_addr` into offset 0x2C and `cap_info` into offset 0x30 and sets the status. A pulse while the status is 1 changes neither word.
- R11: `req_ready` is high exactly in the cycle after a request is accepted, and `req_rdata` is valid in that cycle. Reads of offsets with no register return 0.
- R12: Bit 32*w+b of `lut_bits` equals bit b of table word w, and it follows each table write from the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 write, 0 read |
| req_word_addr | input | 10 | Word address (byte offset divided by 4) |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes, bit i for byte lane i |
| req_secure | input | 1 | Secure attribute of the request |
| req_ready | output | 1 | Completion, one cycle after acceptance |
| req_rdata | output | 32 | Read data, valid with `req_ready` |
| cap_valid | input | 1 | Violation capture strobe from the gate |
| cap_addr | input | 32 | Address of the blocked transfer |
| cap_info | input | 32 | Master and attribute word of the blocked transfer |
| lut_bits | output | 32*table words | Flattened security table, 1 = non-secure block |
| gate_err_resp | output | 1 | Control bit 4 to the gate |
| irq | output | 1 | Interrupt, status AND enable |

## Verification
The hardest state to reach from the ports is a violation capture that arrives while the status is already set, checked at the same time as a pending clear, or after lockdown has frozen the enable. Random traffic reaches it by interleaving capture pulses with random set, clear and enable writes, and a directed run pulses a second capture on purpose. Index wrap is reached by writing the last index directly and then making full-word window accesses with auto-advance enabled. Sub-word merging is covered by random strobe patterns against a bench model.

// File: rtl/sec_lut_pkg.sv
package sec_lut_pkg;

    // byte offsets of the register map
    localparam logic [11:0] OFS_CTRL    = 12'h000;
    localparam logic [11:0] OFS_BMAX    = 12'h010;
    localparam logic [11:0] OFS_BCFG    = 12'h014;
    localparam logic [11:0] OFS_IDX     = 12'h018;
    localparam logic [11:0] OFS_WIN     = 12'h01C;
    localparam logic [11:0] OFS_STAT    = 12'h020;
    localparam logic [11:0] OFS_CLR     = 12'h024;
    localparam logic [11:0] OFS_EN      = 12'h028;
    localparam logic [11:0] OFS_INFO1   = 12'h02C;
    localparam logic [11:0] OFS_INFO2   = 12'h030;
    localparam logic [11:0] OFS_SET     = 12'h034;
    localparam logic [11:0] OFS_ID_BASE = 12'hFD0;

    localparam int CTRL_ERR_BIT  = 4;
    localparam int CTRL_INC_BIT  = 8;
    localparam int CTRL_LOCK_BIT = 31;

    localparam logic [31:0] CTRL_KEEP  = (32'h1 << CTRL_ERR_BIT) |
                                         (32'h1 << CTRL_INC_BIT) |
                                         (32'h1 << CTRL_LOCK_BIT);
    localparam logic [31:0] CTRL_RESET = 32'h1 << CTRL_INC_BIT;

    typedef struct packed {
        logic        stat;
        logic        en;
        logic [31:0] info1;
        logic [31:0] info2;
    } irq_regs_t;

    function automatic logic [31:0] strb_mask(input logic [3:0] strb);
        return {{8{strb[3]}}, {8{strb[2]}}, {8{strb[1]}}, {8{strb[0]}}};
    endfunction

    function automatic logic [7:0] id_byte(input logic [3:0] k);
        case (k)
            4'd0:    return 8'h04;
            4'd4:    return 8'h60;
            4'd5:    return 8'hB8;
            4'd6:    return 8'h1B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/slr_lut_store.sv
module slr_lut_store #(
    parameter int WORDS = 8,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [31:0]           wr_data,
    input  logic [IW-1:0]         rd_idx,
    output logic [31:0]           rd_data,
    output logic [WORDS*32-1:0]   bits_flat
);
    logic [31:0] word_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [31:0] word_d;
        always_comb begin
            word_d = word_q[w];
            if (wr_en && (wr_idx == IW'(w))) word_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[w] <= '0;
            else        word_q[w] <= word_d;
        end
        assign bits_flat[w*32 +: 32] = word_q[w];
    end

    assign rd_data = word_q[rd_idx];

    // R12: a write is visible on the flat export one cycle later
    a_r12_export_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bits_flat[32*$past(wr_idx) +: 32] == $past(wr_data))
        else $error("table export did not follow write");
endmodule

// File: rtl/slr_id_rom.sv
module slr_id_rom
    import sec_lut_pkg::*;
(
    input  logic [11:0] ofs,
    output logic        hit,
    output logic [31:0] data
);
    logic [11:0] rel;
    always_comb begin
        rel  = ofs - OFS_ID_BASE;
        hit  = (ofs >= OFS_ID_BASE);
        data = hit ? {24'h0, id_byte(rel[5:2])} : 32'h0;
    end
endmodule

// File: rtl/sec_lut_regbank.sv
module sec_lut_regbank
    import sec_lut_pkg::*;
#(
    parameter int MEM_BYTES = 65536,
    parameter int BLK_BYTES = 256,
    localparam int NBLK      = (MEM_BYTES + BLK_BYTES - 1) / BLK_BYTES,
    localparam int WORDS_RAW = (NBLK + 31) / 32,
    localparam int LUT_WORDS = (WORDS_RAW < 1) ? 1 : WORDS_RAW,
    localparam int IW        = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [9:0]                req_word_addr,
    input  logic [31:0]               req_wdata,
    input  logic [3:0]                req_strb,
    input  logic                      req_secure,
    output logic                      req_ready,
    output logic [31:0]               req_rdata,
    input  logic                      cap_valid,
    input  logic [31:0]               cap_addr,
    input  logic [31:0]               cap_info,
    output logic [LUT_WORDS*32-1:0]   lut_bits,
    output logic                      gate_err_resp,
    output logic                      irq
);
    localparam logic [31:0] BMAX_VAL = 32'(LUT_WORDS - 1);
    localparam logic [31:0] BCFG_VAL = 32'($clog2(BLK_BYTES) - 5);

    typedef struct packed {
        logic [31:0] ctrl;
        logic [IW-1:0] idx;
        irq_regs_t   ints;
        logic        ready;
        logic [31:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [11:0] ofs;
    logic        accept, ns_blocked, do_wr, do_rd, full_word, locked, advance;
    logic [31:0] old_val, wr_val, lut_cur;
    logic        lut_we;
    logic        id_hit;
    logic [31:0] id_data;

    slr_lut_store #(.WORDS(LUT_WORDS)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (lut_we),
        .wr_idx    (st_q.idx),
        .wr_data   (wr_val),
        .rd_idx    (st_q.idx),
        .rd_data   (lut_cur),
        .bits_flat (lut_bits)
    );

    slr_id_rom i_id (
        .ofs  (ofs),
        .hit  (id_hit),
        .data (id_data)
    );

    always_comb begin
        ofs        = {req_word_addr, 2'b00};
        accept     = req_valid && !st_q.ready;
        ns_blocked = !req_secure && (ofs < OFS_ID_BASE);
        do_wr      = accept && req_write && !ns_blocked;
        do_rd      = accept && !req_write && !ns_blocked;
        full_word  = (req_strb == 4'hF);
        locked     = st_q.ctrl[CTRL_LOCK_BIT];

        case (ofs)
            OFS_CTRL: old_val = st_q.ctrl;
            OFS_IDX:  old_val = 32'(st_q.idx);
            OFS_WIN:  old_val = lut_cur;
            default:  old_val = 32'h0;
        endcase
        wr_val = (old_val & ~strb_mask(req_strb)) | (req_wdata & strb_mask(req_strb));

        st_d       = st_q;
        st_d.ready = accept;
        lut_we     = 1'b0;
        advance    = 1'b0;
        if (accept) st_d.rdata = 32'h0;

        if (do_wr) begin
            case (ofs)
                OFS_CTRL: if (!locked) st_d.ctrl = wr_val & CTRL_KEEP;
                OFS_IDX:  st_d.idx = IW'(wr_val % 32'(LUT_WORDS));
                OFS_WIN:  if (!locked) begin
                              lut_we  = 1'b1;
                              advance = full_word;
                          end
                OFS_CLR:  if (wr_val[0]) st_d.ints.stat = 1'b0;
                OFS_EN:   if (!locked) st_d.ints.en = wr_val[0];
                OFS_SET:  if (wr_val[0]) st_d.ints.stat = 1'b1;
                default:  ;
            endcase
        end

        if (do_rd) begin
            case (ofs)
                OFS_CTRL:  st_d.rdata = st_q.ctrl;
                OFS_BMAX:  st_d.rdata = BMAX_VAL;
                OFS_BCFG:  st_d.rdata = BCFG_VAL;
                OFS_IDX:   st_d.rdata = 32'(st_q.idx);
                OFS_WIN:   begin
                               st_d.rdata = lut_cur;
                               advance    = full_word;
                           end
                OFS_STAT:  st_d.rdata = {31'h0, st_q.ints.stat};
                OFS_EN:    st_d.rdata = {31'h0, st_q.ints.en};
                OFS_INFO1: st_d.rdata = st_q.ints.info1;
                OFS_INFO2: st_d.rdata = st_q.ints.info2;
                default:   st_d.rdata = id_hit ? id_data : 32'h0;
            endcase
        end

        if (advance && st_q.ctrl[CTRL_INC_BIT])
            st_d.idx = (st_q.idx == IW'(LUT_WORDS - 1)) ? '0 : st_q.idx + 1'b1;

        // capture from the gate only while nothing is pending
        if (cap_valid && !st_q.ints.stat) begin
            st_d.ints.info1 = cap_addr;
            st_d.ints.info2 = cap_info;
            st_d.ints.stat  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= CTRL_RESET;
            st_q.idx   <= '0;
            st_q.ints  <= '{stat: 1'b0, en: 1'b1, info1: 32'h0, info2: 32'h0};
            st_q.ready <= 1'b0;
            st_q.rdata <= 32'h0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready     = st_q.ready;
    assign req_rdata     = st_q.rdata;
    assign gate_err_resp = st_q.ctrl[CTRL_ERR_BIT];
    assign irq           = st_q.ints.stat && st_q.ints.en;

    // R6: lockdown is sticky until reset
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl[CTRL_LOCK_BIT] |=> st_q.ctrl[CTRL_LOCK_BIT])
        else $error("lockdown dropped");

    // R6: table frozen against window writes under lockdown
    a_r6_lock_table: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && locked && ofs == OFS_WIN) |=> $stable(lut_bits))
        else $error("table changed under lockdown");

    // R5: non-secure access below the ID space leaves control and table alone
    a_r5_ns_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ns_blocked) |=> ($stable(st_q.ctrl) && $stable(lut_bits) && $stable(st_q.idx)))
        else $error("non-secure access changed state");

    // R11: completion one cycle after acceptance, single cycle wide
    a_r11_ready_next: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> req_ready)
        else $error("no ready after accept");
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready)
        else $error("ready held two cycles");

    // R10: capture words hold while a violation is pending
    a_r10_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ints.stat |=> ($stable(st_q.ints.info1) && $stable(st_q.ints.info2)))
        else $error("capture overwritten while pending");

    // R4: index stays inside the table
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.idx) < 32'(LUT_WORDS))
        else $error("index out of range");
endmodule

// File: tb/test_sec_lut_regbank.sv
module test_sec_lut_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 65536;
    localparam int BLK_BYTES  = 256;
    localparam int WORDS      = 8;
    localparam logic [7:0] ID_TAB [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h60, 8'hB8,
                                           8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_secure = 1, cap_valid = 0;
    logic [9:0]  req_word_addr = '0;
    logic [31:0] req_wdata = '0, cap_addr = '0, cap_info = '0;
    logic [3:0]  req_strb = '0;
    logic        req_ready, gate_err_resp, irq;
    logic [31:0] req_rdata;
    logic [WORDS*32-1:0] lut_bits;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_ctrl, m_lut [WORDS], m_info1, m_info2;
    int          m_idx;
    logic        m_stat, m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_lut_regbank #(.MEM_BYTES(MEM_BYTES), .BLK_BYTES(BLK_BYTES)) i_sec_lut_regbank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word_addr(req_word_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .req_secure(req_secure), .req_ready(req_ready), .req_rdata(req_rdata),
        .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_info(cap_info),
        .lut_bits(lut_bits), .gate_err_resp(gate_err_resp), .irq(irq));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] bmask(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] o, input bit sec);
        if (!sec && o < 12'hFD0) return 32'h0;
        if (o >= 12'hFD0) return {24'h0, ID_TAB[(o - 12'hFD0) >> 2]};
        case (o)
            12'h000: return m_ctrl;
            12'h010: return 32'(WORDS - 1);
            12'h014: return 32'($clog2(BLK_BYTES) - 5);
            12'h018: return 32'(m_idx);
            12'h01C: return m_lut[m_idx];
            12'h020: return {31'h0, m_stat};
            12'h028: return {31'h0, m_en};
            12'h02C: return m_info1;
            12'h030: return m_info2;
            default: return 32'h0;
        endcase
    endfunction

    function automatic void model_advance();
        if (m_ctrl[8]) m_idx = (m_idx + 1) % WORDS;
    endfunction

    function automatic void model_write(input logic [11:0] o, input logic [31:0] d,
                                        input logic [3:0] s, input bit sec);
        logic [31:0] old, v;
        bit lk;
        if (!sec && o < 12'hFD0) return;
        lk = m_ctrl[31];
        case (o)
            12'h000: old = m_ctrl;
            12'h018: old = 32'(m_idx);
            12'h01C: old = m_lut[m_idx];
            default: old = 32'h0;
        endcase
        v = (old & ~bmask(s)) | (d & bmask(s));
        case (o)
            12'h000: if (!lk) m_ctrl = v & 32'h8000_0110;
            12'h018: m_idx = int'(v % WORDS);
            12'h01C: if (!lk) begin
                         m_lut[m_idx] = v;
                         if (s == 4'hF) model_advance();
                     end
            12'h024: if (v[0]) m_stat = 1'b0;
            12'h028: if (!lk) m_en = v[0];
            12'h034: if (v[0]) m_stat = 1'b1;
            default: ;
        endcase
    endfunction

    task automatic bus(input bit wr, input logic [11:0] o, input logic [31:0] d,
                       input logic [3:0] s, input bit sec, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_word_addr = o[11:2];
        req_wdata = d; req_strb = s; req_secure = sec;
        @(negedge clk);
        check("R11 ready", {31'h0, req_ready}, 32'h1);
        rd = req_rdata;
        req_valid = 0;
    endtask

    task automatic wr(input logic [11:0] o, input logic [31:0] d, input logic [3:0] s,
                      input bit sec);
        logic [31:0] dummy;
        bus(1, o, d, s, sec, dummy);
        model_write(o, d, s, sec);
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] o, input logic [3:0] s,
                          input bit sec);
        logic [31:0] got, exp;
        exp = model_read(o, sec);
        bus(0, o, 32'h0, s, sec, got);
        check(tag, got, exp);
        if ((sec || o >= 12'hFD0) && o == 12'h01C && s == 4'hF) model_advance();
    endtask

    task automatic capture(input logic [31:0] a, input logic [31:0] inf);
        @(negedge clk);
        cap_valid = 1; cap_addr = a; cap_info = inf;
        @(negedge clk);
        cap_valid = 0;
        if (!m_stat) begin m_info1 = a; m_info2 = inf; m_stat = 1; end
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " R8 irq"}, {31'h0, irq}, {31'h0, m_stat & m_en});
        check({tag, " R2 err_resp"}, {31'h0, gate_err_resp}, {31'h0, m_ctrl[4]});
        for (int w = 0; w < WORDS; w++)
            check({tag, " R12 lut_bits"}, lut_bits[w*32 +: 32], m_lut[w]);
    endtask

    localparam logic [11:0] OFS_LIST [16] = '{12'h000, 12'h010, 12'h014, 12'h018, 12'h01C,
        12'h01C, 12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h040, 12'hFD0,
        12'hFE4, 12'hFFC};
    localparam logic [3:0] STRB_LIST [8] = '{4'hF, 4'hF, 4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC};

    initial begin
        logic [31:0] tmp;
        m_ctrl = 32'h100; m_idx = 0; m_stat = 0; m_en = 1; m_info1 = 0; m_info2 = 0;
        for (int w = 0; w < WORDS; w++) m_lut[w] = 0;
        void'($urandom(32'h5EC1));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check_outputs("R1 reset");
        rd_chk("R1 ctrl", 12'h000, 4'hF, 1);
        rd_chk("R1 idx", 12'h018, 4'hF, 1);
        rd_chk("R1 stat", 12'h020, 4'hF, 1);
        rd_chk("R1 en", 12'h028, 4'hF, 1);
        rd_chk("R1 info1", 12'h02C, 4'hF, 1);
        rd_chk("R1 info2", 12'h030, 4'hF, 1);
        // R4 geometry
        rd_chk("R4 bmax", 12'h010, 4'hF, 1);
        rd_chk("R4 bcfg", 12'h014, 4'hF, 1);
        // R9 ID space, both security levels, write ignored
        for (int k = 0; k < 12; k++) rd_chk("R9 id", 12'(12'hFD0 + 4*k), 4'hF, k % 2 == 0);
        wr(12'hFD4, 32'hFFFF_FFFF, 4'hF, 1);
        rd_chk("R9 id after write", 12'hFD4, 4'hF, 1);
        // R2 control mask
        wr(12'h000, 32'h7FFF_FFFF, 4'hF, 1);
        rd_chk("R2 ctrl mask", 12'h000, 4'hF, 1);
        check_outputs("R2");
        // R4 index modulo
        wr(12'h018, 32'd13, 4'hF, 1);
        rd_chk("R4 idx modulo", 12'h018, 4'hF, 1);
        // R3 wrap: last index, full write advances to 0
        wr(12'h018, 32'd7, 4'hF, 1);
        wr(12'h01C, 32'hA5A5_0001, 4'hF, 1);
        rd_chk("R3 idx wrapped", 12'h018, 4'hF, 1);
        check_outputs("R3 wrap");
        // R3/R7 sub-word write merges and does not advance
        wr(12'h018, 32'd7, 4'hF, 1);
        wr(12'h01C, 32'h0000_3C00, 4'h2, 1);
        rd_chk("R3 no advance", 12'h018, 4'hF, 1);
        rd_chk("R7 merged lut", 12'h01C, 4'h1, 1);
        // R7 zero-extend on enable: byte write in lane 1 clears bit 0
        wr(12'h028, 32'h0000_0101, 4'h2, 1);
        rd_chk("R7 en zero-extend", 12'h028, 4'hF, 1);
        wr(12'h028, 32'h1, 4'hF, 1);
        // R5 non-secure
        rd_chk("R5 ns ctrl read", 12'h000, 4'hF, 0);
        wr(12'h000, 32'h0000_0010, 4'hF, 0);
        wr(12'h01C, 32'hFFFF_FFFF, 4'hF, 0);
        rd_chk("R5 ns write ignored", 12'h000, 4'hF, 1);
        check_outputs("R5");
        // R8 set/clear
        wr(12'h034, 32'h1, 4'hF, 1);
        check_outputs("R8 set");
        rd_chk("R8 set reads zero", 12'h034, 4'hF, 1);
        rd_chk("R8 clr reads zero", 12'h024, 4'hF, 1);
        wr(12'h024, 32'h1, 4'hF, 1);
        check_outputs("R8 clear");
        // R10 capture then ignored second capture
        capture(32'h0000_1234, 32'h0001_0007);
        capture(32'hDEAD_BEEF, 32'hFFFF_FFFF);
        rd_chk("R10 info1", 12'h02C, 4'hF, 1);
        rd_chk("R10 info2", 12'h030, 4'hF, 1);
        check_outputs("R10");
        rd_chk("R11 undefined", 12'h040, 4'hF, 1);

        // random phase
        for (int n = 0; n < 600; n++) begin
            logic [11:0] o;
            logic [31:0] d;
            logic [3:0]  s;
            bit sec;
            o   = OFS_LIST[$urandom_range(0, 15)];
            s   = STRB_LIST[$urandom_range(0, 7)];
            sec = ($urandom_range(0, 9) != 0);
            d   = $urandom();
            if (o == 12'h000) d[31] = 1'b0;
            if ($urandom_range(0, 9) == 0) capture($urandom(), $urandom());
            if ($urandom_range(0, 1) == 1) wr(o, d, s, sec);
            else rd_chk("R3 random read", o, s, sec);
            check_outputs("R8 random");
        end

        // R6 lockdown
        wr(12'h000, 32'h8000_0100, 4'hF, 1);
        for (int w = 0; w < WORDS; w++) tmp = m_lut[w];
        wr(12'h000, 32'h0000_0010, 4'hF, 1);
        rd_chk("R6 ctrl frozen", 12'h000, 4'hF, 1);
        wr(12'h018, 32'd2, 4'hF, 1);
        wr(12'h01C, ~m_lut[2], 4'hF, 1);
        rd_chk("R6 idx not advanced", 12'h018, 4'hF, 1);
        wr(12'h028, 32'h0, 4'hF, 1);
        rd_chk("R6 en frozen", 12'h028, 4'hF, 1);
        wr(12'h034, 32'h1, 4'hF, 1);
        check_outputs("R6");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule